// File: doc/BRIEF.md
# Serial-Stage 16-bit Processor Core

This block is a small non-pipelined processor with 16-bit instructions and a 16-bit program counter. It runs four operations: two-operand add, two-operand bitwise and, bitwise complement, and an effective-address computation relative to the PC. Each instruction goes through its stages strictly in turn before the next one is read, so two instructions never overlap.

Instruction memory is external and synchronous. The core presents the PC as the address with a one-cycle read strobe. It captures the returned word one cycle later. Each instruction takes five clocks:

1. fetch
2. capture wait
3. decode
4. execute
5. writeback

The PC, the eight general registers and the condition flags are driven out on debug ports so that a system or a bench can follow the architectural state.

Top module: `seq16_core`

## Requirements
- R1: While reset is high and right after it is released, the PC reads 0x3000, all eight registers read zero and the flags read Z (dbg_cc = 3'b010). The first read strobe after release presents address 0x3000.
- R2: The read strobe is high for exactly one cycle in each five-cycle instruction, and `imem_addr` equals the PC while it is high. The word on `imem_data` in the cycle after the strobe is the instruction executed. The PC and the registers change only at the clock edge that ends the fifth cycle.
- R3: Opcode bits [15:12] = 0001 is ADD. DR is [11:9] and SR1 is [8:6]. When bit 5 is 0 the second operand is the register at [2:0]. When bit 5 is 1 the second operand is [4:0] sign-extended. The sum wraps modulo 2^16.
- R4: Opcode 0101 is AND, with the same field layout as R3, and it writes the bitwise AND of its operands to DR.
- R5: Opcode 1001 is NOT, which writes the bitwise complement of the register at [8:6] to the register at [11:9].
- R6: Opcode 1110 is LEA, which writes (address of the instruction + 1) plus the sign-extended 9-bit field [8:0] to the register at [11:9], modulo 2^16.
- R7: The flags `dbg_cc` are {N,Z,P} in bits [2:1:0]. Exactly one is set at all times. Every register write sets them from the written value: N for bit 15 set, Z for zero, P otherwise.
- R8: Any other opcode changes no register and no flag. It still takes five cycles and still advances the PC.
- R9: Each completed instruction adds exactly one to the PC.
- R10: Asserting reset in the middle of an instruction abandons it. After release, execution restarts at 0x3000 from cleared registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Instruction address (the PC) |
| imem_rd | output | 1 | Instruction read strobe, high in the fetch cycle |
| imem_data | input | 16 | Instruction word from synchronous memory, one cycle after the strobe |
| dbg_pc | output | 16 | Current PC |
| dbg_rf | output | 128 | All registers, register k in bits [16k+15:16k] |
| dbg_cc | output | 3 | Condition flags {N,Z,P} |

## Verification
The bench targets the following corner cases:

- **Sum that overflows 16 bits.** A core with the wrong width or sign handling shows a wrong register value or a wrong N flag.
- **Negative immediates and a negative address offset.** Missing sign extension leaves a large positive result instead.
- **An add whose destination is also its source.** This exposes a write that lands a cycle early.
- **An unsupported opcode in mid-program.** This catches cores that write a register, disturb the flags or stall the PC.
- **Register and PC state checked in the four cycles before writeback.** This catches early commits.
- **Reset in the middle of an instruction.** A core that kept stale state would resume at the wrong address or with non-zero registers.

// File: rtl/seq16_pkg.sv
package seq16_pkg;
    localparam int DW   = 16;
    localparam int NREG = 8;
    localparam int RW   = $clog2(NREG);
    localparam logic [DW-1:0] RESET_PC = 16'h3000;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_WAIT   = 3'd1,
        ST_DECODE = 3'd2,
        ST_EXEC   = 3'd3,
        ST_WB     = 3'd4
    } stage_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_AND = 2'd1,
        OP_NOT = 2'd2,
        OP_LEA = 2'd3
    } alu_op_e;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;
    localparam logic [3:0] OPC_LEA = 4'b1110;

    typedef struct packed {
        alu_op_e          op;
        logic             wr_en;
        logic [RW-1:0]    dr;
        logic [RW-1:0]    sr1;
        logic [RW-1:0]    sr2;
        logic             use_imm;
        logic [DW-1:0]    imm;
    } dec_t;

    function automatic logic [DW-1:0] sext5(input logic [4:0] v);
        return {{(DW-5){v[4]}}, v};
    endfunction

    function automatic logic [DW-1:0] sext9(input logic [8:0] v);
        return {{(DW-9){v[8]}}, v};
    endfunction

    function automatic logic [2:0] flags_of(input logic [DW-1:0] v);
        if (v[DW-1])        return 3'b100;
        else if (v == '0)   return 3'b010;
        else                return 3'b001;
    endfunction
endpackage

// File: rtl/seq16_ctrl.sv
module seq16_ctrl
    import seq16_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output stage_e stage
);
    stage_e stage_nx;

    always_comb begin
        unique case (stage)
            ST_FETCH:  stage_nx = ST_WAIT;
            ST_WAIT:   stage_nx = ST_DECODE;
            ST_DECODE: stage_nx = ST_EXEC;
            ST_EXEC:   stage_nx = ST_WB;
            default:   stage_nx = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stage <= ST_FETCH;
        else     stage <= stage_nx;
    end
endmodule

// File: rtl/seq16_decode.sv
module seq16_decode
    import seq16_pkg::*;
(
    input  logic [DW-1:0] ir,
    output dec_t          dec
);
    always_comb begin
        dec         = '0;
        dec.dr      = ir[11:9];
        dec.sr1     = ir[8:6];
        dec.sr2     = ir[2:0];
        dec.use_imm = ir[5];
        dec.imm     = sext5(ir[4:0]);
        unique case (ir[15:12])
            OPC_ADD: begin dec.op = OP_ADD; dec.wr_en = 1'b1; end
            OPC_AND: begin dec.op = OP_AND; dec.wr_en = 1'b1; end
            OPC_NOT: begin dec.op = OP_NOT; dec.wr_en = 1'b1; end
            OPC_LEA: begin
                dec.op      = OP_LEA;
                dec.wr_en   = 1'b1;
                dec.use_imm = 1'b1;
                dec.imm     = sext9(ir[8:0]);
            end
            default: dec.wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/seq16_alu.sv
module seq16_alu
    import seq16_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] npc,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_AND:  y = a & b;
            OP_NOT:  y = ~a;
            default: y = npc + b;
        endcase
    end
endmodule

// File: rtl/seq16_regfile.sv
module seq16_regfile
    import seq16_pkg::*;
#(
    parameter int W = DW,
    parameter int N = NREG
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] raddr_a,
    input  logic [$clog2(N)-1:0] raddr_b,
    output logic [W-1:0]         rdata_a,
    output logic [W-1:0]         rdata_b,
    output logic [N*W-1:0]       dump
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    for (genvar g = 0; g < N; g++) begin : g_dump
        assign dump[g*W +: W] = regs[g];
    end
endmodule

// File: rtl/seq16_core.sv
module seq16_core
    import seq16_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [DW-1:0]      imem_addr,
    output logic               imem_rd,
    input  logic [DW-1:0]      imem_data,
    output logic [DW-1:0]      dbg_pc,
    output logic [NREG*DW-1:0] dbg_rf,
    output logic [2:0]         dbg_cc
);
    stage_e        stage_q;
    logic [DW-1:0] pc_q, npc_q, ir_q, res_q;
    logic [2:0]    cc_q;
    dec_t          dec_w, dec_q;
    logic [DW-1:0] rd_a, rd_b, opnd_b, alu_y;
    logic          rf_we;

    seq16_ctrl u_ctrl (.clk(clk), .rst(rst), .stage(stage_q));

    seq16_decode u_dec (.ir(ir_q), .dec(dec_w));

    assign opnd_b = dec_q.use_imm ? dec_q.imm : rd_b;

    seq16_alu u_alu (
        .op(dec_q.op), .a(rd_a), .b(opnd_b), .npc(npc_q), .y(alu_y)
    );

    assign rf_we = (stage_q == ST_WB) && dec_q.wr_en;

    seq16_regfile u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(dec_q.dr), .wdata(res_q),
        .raddr_a(dec_q.sr1), .raddr_b(dec_q.sr2),
        .rdata_a(rd_a), .rdata_b(rd_b), .dump(dbg_rf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= RESET_PC;
            npc_q <= RESET_PC;
            ir_q  <= '0;
            dec_q <= '0;
            res_q <= '0;
            cc_q  <= 3'b010;
        end else begin
            unique case (stage_q)
                ST_FETCH:  npc_q <= pc_q + 16'd1;
                ST_WAIT:   ir_q  <= imem_data;
                ST_DECODE: dec_q <= dec_w;
                ST_EXEC:   res_q <= alu_y;
                default: begin
                    pc_q <= npc_q;
                    if (dec_q.wr_en) cc_q <= flags_of(res_q);
                end
            endcase
        end
    end

    assign imem_addr = pc_q;
    assign imem_rd   = (stage_q == ST_FETCH);
    assign dbg_pc    = pc_q;
    assign dbg_cc    = cc_q;
endmodule

// File: rtl/seq16_core_chk.sv
module seq16_core_chk
    import seq16_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               imem_rd,
    input logic [DW-1:0]      dbg_pc,
    input logic [NREG*DW-1:0] dbg_rf,
    input logic [2:0]         dbg_cc,
    input stage_e             stage
);
    AST_RD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        imem_rd |=> !imem_rd);                                           // R2

    AST_RD_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
        imem_rd |-> stage == ST_FETCH);                                  // R2

    AST_PC_HOLD_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        imem_rd |=> $stable(dbg_pc));                                    // R2

    AST_RF_WB_ONLY: assert property (@(posedge clk) disable iff (rst)
        (dbg_rf != $past(dbg_rf)) |-> $past(stage) == ST_WB);            // R2

    AST_PC_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (dbg_pc != $past(dbg_pc)) |-> dbg_pc == $past(dbg_pc) + 16'd1);  // R9

    AST_CC_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        $countones(dbg_cc) == 1);                                        // R7
endmodule

bind seq16_core seq16_core_chk u_chk (
    .clk(clk), .rst(rst), .imem_rd(imem_rd), .dbg_pc(dbg_pc),
    .dbg_rf(dbg_rf), .dbg_cc(dbg_cc), .stage(stage_q)
);

// File: tb/seq16_core_bench.sv
module seq16_core_bench;
    localparam int NV = 11;
    // instr[38:23] wr[22] dr[21:19] value[18:3] flags[2:0]
    localparam logic [38:0] VEC [NV] = '{
        {16'hE205, 1'b1, 3'd1, 16'h3006, 3'b001}, // R6 LEA +5
        {16'h1479, 1'b1, 3'd2, 16'h2FFF, 3'b001}, // R3 ADD imm -7
        {16'h96BF, 1'b1, 3'd3, 16'hD000, 3'b100}, // R5 NOT
        {16'h58C1, 1'b1, 3'd4, 16'h1000, 3'b001}, // R4 AND reg
        {16'h5B20, 1'b1, 3'd5, 16'h0000, 3'b010}, // R4 AND imm 0 -> Z
        {16'h1CC3, 1'b1, 3'd6, 16'hA000, 3'b100}, // R3 ADD wraps
        {16'h3E00, 1'b0, 3'd0, 16'h0000, 3'b100}, // R8 no-op
        {16'hEFF8, 1'b1, 3'd7, 16'h3000, 3'b001}, // R6 LEA -8
        {16'h102F, 1'b1, 3'd0, 16'h000F, 3'b001}, // R3 ADD imm +15
        {16'h1FC6, 1'b1, 3'd7, 16'hD000, 3'b100}, // R3 DR=SR1
        {16'h9B7F, 1'b1, 3'd5, 16'hFFFF, 3'b100}  // R5 NOT zero
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  imem_addr, imem_data = '0, dbg_pc;
    logic         imem_rd;
    logic [127:0] dbg_rf;
    logic [2:0]   dbg_cc;
    logic [127:0] shadow;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seq16_core u_seq16_core (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rd(imem_rd),
        .imem_data(imem_data), .dbg_pc(dbg_pc), .dbg_rf(dbg_rf), .dbg_cc(dbg_cc)
    );

    function automatic logic [15:0] rom(input logic [15:0] a);
        logic [15:0] idx = a - 16'h3000;
        if (idx < 16'(NV)) return VEC[idx][38:23];
        return 16'h0000;
    endfunction

    always @(posedge clk) if (imem_rd) imem_data <= rom(imem_addr);

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_reset_state(input string req);
        chk(dbg_pc == 16'h3000, req, dbg_pc, 16'h3000);
        chk(dbg_rf == '0, req, dbg_rf, 0);
        chk(dbg_cc == 3'b010, req, dbg_cc, 3'b010);
        chk(imem_rd && imem_addr == 16'h3000, req, {imem_rd, imem_addr}, {1'b1, 16'h3000});
    endtask

    initial begin
        logic [2:0] cc_exp;
        cc_exp = 3'b010;
        shadow = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dbg_pc == 16'h3000 && dbg_cc == 3'b010, "R1 during reset", {dbg_pc, dbg_cc}, {16'h3000, 3'b010});
        rst = 1'b0;
        check_reset_state("R1");

        for (int i = 0; i < NV; i++) begin
            for (int c = 1; c < 5; c++) begin
                tick();
                chk(!imem_rd, "R2 strobe low", imem_rd, 0);
                chk(dbg_pc == 16'h3000 + 16'(i), "R2 pc held", dbg_pc, 16'h3000 + 16'(i));
                chk(dbg_rf == shadow, "R2 no early write", dbg_rf, shadow);
            end
            tick();
            if (VEC[i][22]) begin
                shadow[VEC[i][21:19]*16 +: 16] = VEC[i][18:3];
                cc_exp = VEC[i][2:0];
            end
            chk(dbg_rf == shadow, VEC[i][22] ? "R3/R4/R5/R6 result" : "R8 no write", dbg_rf, shadow);
            chk(dbg_cc == cc_exp, "R7 flags", dbg_cc, cc_exp);
            chk(dbg_pc == 16'h3001 + 16'(i), "R9 pc step", dbg_pc, 16'h3001 + 16'(i));
            chk(imem_rd && imem_addr == dbg_pc, "R2 next fetch", {imem_rd, imem_addr}, {1'b1, dbg_pc});
        end

        // R10: reset in the middle of an instruction
        tick();
        tick();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        check_reset_state("R10");
        repeat (5) tick();
        chk(dbg_rf[31:16] == 16'h3006 && dbg_pc == 16'h3001, "R10 restart",
            {dbg_rf[31:16], dbg_pc}, {16'h3006, 16'h3001});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule